// File: doc/BRIEF.md
# AGC Serial Word Transmitter

This block sends a 12-bit gain word to a downstream gain-control device over three wires: a serial clock, an active-low frame strobe and a data line. The caller gives a new gain word together with a single-cycle update strobe. The block then sends one frame. Each frame lasts 16 serial clock periods: four zero padding bits come first and the receiver discards them, then the gain bits follow, most significant bit first.

The serial clock is made by dividing the system clock. The half-period, in system cycles, is rounded up so that the serial period is never shorter than a set minimum (200 ns by default). Data and frame strobe change only at rising serial clock edges, so the receiver can capture on falling edges.

The word is copied into the frame shift register when a frame begins. An update that arrives during a frame is therefore held and sent in the next frame. Several updates that arrive before a frame begins collapse into one frame, which carries the most recent word. At least a set number of serial periods of idle line separate consecutive frames.

Top module: `agc_ser_tx`

## Requirements
- R1: After reset the frame strobe is high, the serial clock and data are low, and no frame starts until an update strobe arrives.
- R2: A frame holds the frame strobe low for exactly 16 serial clock pulses. The strobe falls together with the first rising clock edge and rises with the clock low, one full period after the 16th rising edge.
- R3: The first 4 bits of every frame (the first four falling-edge samples) are 0.
- R4: Bits 5 to 16 of a frame carry gain word bit 11 down to bit 0, in that order.
- R5: While a frame is in progress, the data line changes only together with a rising serial clock edge or a change of the frame strobe. It is therefore stable across every falling edge.
- R6: The serial clock is high for HALF system cycles and low for HALF system cycles, where HALF = ceil(MIN_SCLK_PS / (2 * SYS_CLK_PS)). With the defaults HALF is 10, giving a 200 ns period.
- R7: While the frame strobe is high, the serial clock and data stay low.
- R8: An update accepted during a frame does not change that frame; its word is sent in the next frame.
- R9: When several updates arrive before a frame starts, exactly one frame is sent, and it carries the last word.
- R10: Between two frames the strobe stays high for at least GAP_PERIODS * 2 * HALF system cycles.
- R11: When the line is idle with no word pending, an update strobe sampled at clock edge E makes the strobe fall at edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | One-cycle strobe: capture gain_i and request a frame |
| gain_i | input | 12 | Gain word to transmit |
| sclk_o | output | 1 | Serial clock, idles low |
| sync_n_o | output | 1 | Active-low frame strobe |
| data_o | output | 1 | Serial data, padding first, then MSB first |

## Verification
The embedded assertions check the line rules on every cycle: idle levels while the strobe is high, data moving only with a rising clock or strobe change, the strobe falling only together with a rising clock, and the bounds on the period and bit counters. The bench scenarios are needed for the content and ordering of frames. These cover the padding and bit order of captured words, a mid-frame update deferred to the next frame, the coalescing of several pending updates, the measured high and low phase lengths, the minimum idle gap, and the start latency after a strobe.

// File: rtl/agc_ser_pkg.sv
package agc_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } agc_st_e;

    typedef struct packed {
        logic sclk;
        logic sync_n;
    } agc_line_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/agc_ser_hold.sv
module agc_ser_hold #(
    parameter int GAIN_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              upd_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic [GAIN_W-1:0] word_o
);
    logic              pend_q;
    logic [GAIN_W-1:0] word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= 1'b0;
            word_q <= '0;
        end else if (upd_i) begin
            pend_q <= 1'b1;
            word_q <= gain_i;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign word_o = word_q;

    // R9: a taken word clears the request unless a new update came in the same cycle
    p_take_clears_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        take_i && !upd_i |=> !pend_q);
endmodule

// File: rtl/agc_ser_ctrl.sv
module agc_ser_ctrl
    import agc_ser_pkg::*;
#(
    parameter int HALF        = 10,
    parameter int FRAME_W     = 16,
    parameter int GAP_PERIODS = 1
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pend_i,
    output logic      load_o,
    output logic      shift_o,
    output agc_line_t line_o
);
    localparam int PERIOD  = 2 * HALF;
    localparam int GAP_CYC = GAP_PERIODS * PERIOD;
    localparam int CW      = $clog2(max2(PERIOD, GAP_CYC) + 1);
    localparam int BW      = $clog2(FRAME_W + 1);

    agc_st_e       st_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    agc_line_t     line_q;

    logic per_end, last_bit;
    assign per_end  = (cnt_q == CW'(PERIOD - 1));
    assign last_bit = (bit_q == BW'(FRAME_W - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            bit_q  <= '0;
            line_q <= '{sclk: 1'b0, sync_n: 1'b1};
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (pend_i) begin
                        st_q   <= ST_FRAME;
                        cnt_q  <= '0;
                        bit_q  <= '0;
                        line_q <= '{sclk: 1'b1, sync_n: 1'b0};
                    end
                end
                ST_FRAME: begin
                    if (per_end) begin
                        cnt_q <= '0;
                        if (last_bit) begin
                            st_q        <= ST_GAP;
                            line_q.sync_n <= 1'b1;
                        end else begin
                            bit_q       <= bit_q + BW'(1);
                            line_q.sclk <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == CW'(HALF - 1)) line_q.sclk <= 1'b0;
                    end
                end
                default: begin
                    if (cnt_q == CW'(GAP_CYC - 1)) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    assign load_o  = (st_q == ST_IDLE) && pend_i;
    assign shift_o = (st_q == ST_FRAME) && per_end && !last_bit;
    assign line_o  = line_q;

    // R6: the phase counter stays inside one serial period during a frame
    p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q == ST_FRAME |-> cnt_q < CW'(PERIOD));
    // R2: never more than FRAME_W bit slots
    p_bit_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_q < BW'(FRAME_W));
    // R10: a frame is always followed by the gap state
    p_frame_to_gap_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q == ST_FRAME && per_end && last_bit |=> st_q == ST_GAP);
endmodule

// File: rtl/agc_ser_shreg.sv
module agc_ser_shreg #(
    parameter int GAIN_W = 12,
    parameter int PAD_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [GAIN_W-1:0] word_i,
    output logic              bit_o
);
    localparam int FRAME_W = GAIN_W + PAD_W;

    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        sr_q <= '0;
        else if (load_i)  sr_q <= {{PAD_W{1'b0}}, word_i};
        else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end

    assign bit_o = sr_q[FRAME_W-1];

    // R3: the first bit after a load is padding
    p_pad_first_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> !bit_o);
endmodule

// File: rtl/agc_ser_tx.sv
module agc_ser_tx
    import agc_ser_pkg::*;
#(
    parameter int SYS_CLK_PS  = 10000,
    parameter int MIN_SCLK_PS = 200000,
    parameter int GAIN_W      = 12,
    parameter int PAD_W       = 4,
    parameter int GAP_PERIODS = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              upd_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic              sclk_o,
    output logic              sync_n_o,
    output logic              data_o
);
    localparam int HALF    = ceil_div(MIN_SCLK_PS, 2 * SYS_CLK_PS);
    localparam int FRAME_W = GAIN_W + PAD_W;

    logic              pend, load, shift, sbit;
    logic [GAIN_W-1:0] word;
    agc_line_t         line;

    agc_ser_hold #(.GAIN_W(GAIN_W)) u_hold (
        .clk_i(clk_i), .rst_i(rst_i), .upd_i(upd_i), .gain_i(gain_i),
        .take_i(load), .pend_o(pend), .word_o(word)
    );

    agc_ser_ctrl #(.HALF(HALF), .FRAME_W(FRAME_W), .GAP_PERIODS(GAP_PERIODS)) u_ctrl (
        .clk_i(clk_i), .rst_i(rst_i), .pend_i(pend),
        .load_o(load), .shift_o(shift), .line_o(line)
    );

    agc_ser_shreg #(.GAIN_W(GAIN_W), .PAD_W(PAD_W)) u_sr (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .shift_i(shift),
        .word_i(word), .bit_o(sbit)
    );

    assign sclk_o   = line.sclk;
    assign sync_n_o = line.sync_n;
    assign data_o   = sbit & ~line.sync_n;

    // R7: idle line levels outside a frame
    p_idle_lines_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_n_o |-> !sclk_o && !data_o);
    // R5: data moves only with a rising clock or a strobe change
    p_data_edge_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(data_o) |-> $rose(sclk_o) || !$stable(sync_n_o));
    // R2: a frame opens with a rising serial clock
    p_sync_fall_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sync_n_o) |-> sclk_o);
    // R2: a frame closes with the serial clock low
    p_sync_rise_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sync_n_o) |-> !sclk_o);
endmodule

// File: tb/agc_ser_tx_tb.sv
module agc_ser_tx_tb_top;
    localparam int HALF    = 10;
    localparam int GAP_CYC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd = 1'b0;
    logic [11:0] gain = '0;
    logic        sclk, sync_n, data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    agc_ser_tx dut_i (
        .clk_i(clk), .rst_i(rst), .upd_i(upd), .gain_i(gain),
        .sclk_o(sclk), .sync_n_o(sync_n), .data_o(data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // receiver-side monitor, sampling at falling system clock edges
    logic [15:0] frames [0:31];
    int   nfr = 0, nbits = 0, hi_run = 0, lo_run = 0, idle_run = 0;
    int   min_gap = 1000000, half_viol = 0, edge_viol = 0, idle_viol = 0, frame_viol = 0;
    logic [15:0] fr;
    logic p_sclk = 1'b0, p_sync = 1'b1, p_data = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_sync && !sync_n) begin
                if (nfr > 0 && idle_run < min_gap) min_gap = idle_run;
                nbits = 0; fr = '0; hi_run = 0; lo_run = 0;
                if (!sclk) frame_viol++;
            end
            if (!sync_n && p_sclk && !sclk) begin
                fr = {fr[14:0], data}; nbits++;
                if (hi_run != HALF) half_viol++;
                lo_run = 0;
            end
            if (!sync_n && !p_sync && !p_sclk && sclk) begin
                if (lo_run != HALF) half_viol++;
                hi_run = 0;
            end
            if (data != p_data && !(sclk && !p_sclk) && sync_n == p_sync) edge_viol++;
            if (!p_sync && sync_n) begin
                if (nbits != 16 || sclk) frame_viol++;
                if (lo_run != HALF) half_viol++;
                if (nfr < 32) frames[nfr] = fr;
                nfr++; idle_run = 0;
            end
            if (sync_n) begin
                idle_run++;
                if (sclk || data) idle_viol++;
            end else if (sclk) hi_run++;
            else lo_run++;
        end
        p_sclk = sclk; p_sync = sync_n; p_data = data;
    end

    task automatic send(input logic [11:0] w);
        @(negedge clk); gain = w; upd = 1'b1;
        @(negedge clk); upd = 1'b0;
    endtask

    task automatic wait_nfr(input int n);
        while (nfr < n) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 sync_n", sync_n, 1); chk("R1 sclk", sclk, 0);
        chk("R1 data", data, 0);     chk("R1 no frame", nfr, 0);
    endtask

    task automatic t_latency();
        @(negedge clk); gain = 12'hA5C; upd = 1'b1;
        @(negedge clk); upd = 1'b0;
        chk("R11 sync high after strobe edge", sync_n, 1);
        @(negedge clk);
        chk("R11 sync low one edge later", sync_n, 0);
        wait_nfr(1);
        chk("R3 padding", frames[0][15:12], 0);
        chk("R4 word A5C", frames[0][11:0], 12'hA5C);
    endtask

    task automatic t_patterns();
        logic [11:0] pats [3] = '{12'hFFF, 12'h001, 12'h800};
        for (int i = 0; i < 3; i++) begin
            int base = nfr;
            send(pats[i]);
            wait_nfr(base + 1);
            chk("R3 padding", frames[base][15:12], 0);
            chk("R4 word", frames[base][11:0], pats[i]);
        end
    endtask

    task automatic t_midframe();
        int base = nfr;
        send(12'h3C3);
        repeat (60) @(negedge clk);
        chk("R8 frame in progress", sync_n, 0);
        send(12'h5A5);
        wait_nfr(base + 2);
        chk("R8 current frame kept", frames[base][11:0], 12'h3C3);
        chk("R8 next frame new word", frames[base + 1][11:0], 12'h5A5);
    endtask

    task automatic t_coalesce();
        int base = nfr;
        send(12'h0F0);
        repeat (30) @(negedge clk);
        send(12'h111); send(12'h222); send(12'h333);
        wait_nfr(base + 2);
        repeat (500) @(negedge clk);
        chk("R9 one extra frame", nfr, base + 2);
        chk("R9 last word wins", frames[base + 1][11:0], 12'h333);
    endtask

    task automatic t_line_rules();
        chk("R2 frame shape", frame_viol, 0);
        chk("R5 data edges", edge_viol, 0);
        chk("R6 half period", half_viol, 0);
        chk("R7 idle levels", idle_viol, 0);
        chk("R10 gap", (min_gap >= GAP_CYC) ? 1 : 0, 1);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_latency(); t_patterns();
                t_midframe(); t_coalesce(); t_line_rules();
            end
            begin
                repeat (100000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule